// File: doc/BRIEF.md
# Time-Slot Multiplexed Frame Serializer

This block turns a set of parallel byte channels into one serial bit stream divided into fixed frames. Each frame holds 32 timeslots of 8 bits each, so a frame lasts 256 bit times. A free-running position counter, advanced by the bit clock, splits into two fields. The low field is the bit index inside the current timeslot. The high field is the timeslot index.

The block shows the number of the timeslot it will send next on a registered select output. The surrounding logic uses that number to address its channel storage and returns the chosen byte on the byte input. In the last bit time of each timeslot, the block loads that byte into a shift register. It then sends the byte most significant bit first during the following timeslot. One bit time before every frame boundary, a frame marker pulses high for a single bit time.

A channel byte of all zeros would leave the line with no transitions for a whole timeslot. Such a byte is therefore replaced by 00000010 when it is loaded.

Top module: `tdm_frame_serializer`

## Requirements
- R1: Synchronous active-high reset sets the position counter to 0, fills the shift register with ones, and drives `frame_sync` low and `slot_sel` to 0. In the first bit time after reset is released, `ser_data` is 1, `frame_sync` is 0 and `slot_sel` is 0.
- R2: Let bit time n be the n-th clock period after reset release, counting from 0. `frame_sync` is 1 exactly in the bit times where n mod 256 equals 255.
- R3: In bit time n, `slot_sel` equals ((n+1) div 8) mod 32. It changes value only when entering bit index 7 of a timeslot, so it holds steady for the whole load cycle.
- R4: The byte on `slot_byte` during bit index 7 of timeslot k is sent in timeslot k+1 (mod 32), most significant bit first. Bit 7 of the byte appears in bit index 0, and bit 0 of the byte appears in bit index 7.
- R5: A loaded byte equal to 8'h00 is sent as 8'h02. That is, bit index 6 of the timeslot carries 1 and every other bit index carries 0.
- R6: A loaded byte other than 8'h00 is sent unchanged. This includes 8'h02, 8'h80, 8'h01 and 8'hFF.
- R7: Timeslot 0 of the first frame after reset sends eight ones, because no byte has been loaded yet.
- R8: Asserting reset in the middle of a timeslot abandons the partial byte. Bit-time numbering then restarts from 0 at release, so R2 to R7 hold from that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slot_sel | output | 5 | Registered number of the timeslot whose byte is requested |
| slot_byte | input | 8 | Byte of the channel addressed by `slot_sel` |
| ser_data | output | 1 | Serial line data, MSB of each timeslot first |
| frame_sync | output | 1 | One-bit-time pulse in the last bit time of each frame |

## Verification
The hardest case to reach is a zero byte loaded exactly at the frame wrap. In that case the load edge, the end of the frame-marker pulse and the counter rollover all fall in one clock. It also requires that the byte at the end of the last timeslot was sampled from the right channel address. The stimulus forces channel 0 and channel 31 to zero and places other boundary bytes (8'h02, 8'h80, 8'h01, 8'hFF) in fixed slots. It then reshuffles all channels from a seeded random source in the middle of each frame, so that several wraps cover mixed contents. A reset pulse in the middle of a timeslot confirms that the partial byte is dropped and the frame timing restarts.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_NUM_SLOTS = 32;
    localparam int DEF_FILL_CODE = 2;

    // Where the counter stands inside a timeslot
    typedef enum logic [1:0] {
        PH_SHIFT = 2'd0,   // ordinary bit time, shift one bit out
        PH_PREP  = 2'd1,   // second-to-last bit: advance the slot request
        PH_LOAD  = 2'd2    // last bit: load the next byte at its end
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   frame_last;   // last bit time of the frame
    } tick_t;

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
    import tdm_pkg::*;
#(
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output tick_t             tick,
    output logic [SLOT_W-1:0] slot_req,
    output logic              sync_q
);

    localparam int CNT_W = BIT_W + SLOT_W;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SLOT_BITS * NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0] LOAD_BIT = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0] PREP_BIT = BIT_W'(SLOT_BITS - 2);

    logic [CNT_W-1:0]  pos_q;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;

    assign bit_idx  = pos_q[BIT_W-1:0];
    assign slot_idx = pos_q[CNT_W-1:BIT_W];

    always_comb begin
        if (bit_idx == LOAD_BIT)
            tick.phase = PH_LOAD;
        else if (bit_idx == PREP_BIT)
            tick.phase = PH_PREP;
        else
            tick.phase = PH_SHIFT;
        tick.frame_last = (pos_q == LAST_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            slot_req <= '0;
            sync_q   <= 1'b0;
        end else begin
            pos_q  <= pos_q + CNT_W'(1);
            sync_q <= (pos_q == LAST_POS - CNT_W'(1));
            if (tick.phase == PH_PREP)
                slot_req <= slot_idx + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/tdm_fill_sub.sv
module tdm_fill_sub #(
    parameter int SLOT_BITS = tdm_pkg::DEF_SLOT_BITS,
    parameter bit FILL_EN   = 1'b1,
    parameter int FILL_CODE = tdm_pkg::DEF_FILL_CODE
) (
    input  logic [SLOT_BITS-1:0] raw,
    output logic [SLOT_BITS-1:0] coded
);

    localparam logic [SLOT_BITS-1:0] FILL_V = SLOT_BITS'(FILL_CODE);

    generate
        if (FILL_EN) begin : g_fill
            always_comb coded = (raw == '0) ? FILL_V : raw;
        end else begin : g_pass
            always_comb coded = raw;
        end
    endgenerate

endmodule

// File: rtl/tdm_piso.sv
module tdm_piso #(
    parameter int SLOT_BITS = tdm_pkg::DEF_SLOT_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SLOT_BITS-1:0] par_in,
    output logic                 ser_out
);

    logic [SLOT_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else if (load)
            sh_q <= par_in;
        else
            sh_q <= {sh_q[SLOT_BITS-2:0], 1'b1};
    end

    assign ser_out = sh_q[SLOT_BITS-1];

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
    import tdm_pkg::*;
#(
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter bit FILL_EN   = 1'b1,
    parameter int FILL_CODE = DEF_FILL_CODE,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [SLOT_W-1:0]    slot_sel,
    input  logic [SLOT_BITS-1:0] slot_byte,
    output logic                 ser_data,
    output logic                 frame_sync
);

    tick_t                tick;
    logic [SLOT_BITS-1:0] coded_byte;
    logic                 load_now;

    tdm_frame_counter #(
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slot_req (slot_sel),
        .sync_q   (frame_sync)
    );

    tdm_fill_sub #(
        .SLOT_BITS (SLOT_BITS),
        .FILL_EN   (FILL_EN),
        .FILL_CODE (FILL_CODE)
    ) u_fill (
        .raw   (slot_byte),
        .coded (coded_byte)
    );

    assign load_now = (tick.phase == PH_LOAD);

    tdm_piso #(
        .SLOT_BITS (SLOT_BITS)
    ) u_piso (
        .clk     (clk),
        .rst     (rst),
        .load    (load_now),
        .par_in  (coded_byte),
        .ser_out (ser_data)
    );

endmodule

// File: rtl/tdm_frame_serializer_chk.sv
module tdm_frame_serializer_chk #(
    parameter int SLOT_BITS = tdm_pkg::DEF_SLOT_BITS,
    parameter int NUM_SLOTS = tdm_pkg::DEF_NUM_SLOTS,
    parameter bit FILL_EN   = 1'b1,
    parameter int FILL_CODE = tdm_pkg::DEF_FILL_CODE,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [SLOT_W-1:0]    slot_sel,
    input logic [SLOT_BITS-1:0] slot_byte,
    input logic                 ser_data,
    input logic                 frame_sync
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam int CNT_W = BIT_W + SLOT_W;
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(SLOT_BITS * NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0] END_B  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_BITS-1:0] FILL_V = SLOT_BITS'(FILL_CODE);
    localparam logic FILL_TOP = FILL_EN ? FILL_V[SLOT_BITS-1] : 1'b0;

    logic [CNT_W-1:0] t_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q     <= '0;
            armed_q <= 1'b0;
        end else begin
            t_q     <= t_q + CNT_W'(1);
            armed_q <= 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> (ser_data && !frame_sync && slot_sel == '0));

    // R2
    sync_pos_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync == (t_q == LAST_T));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && t_q[BIT_W-1:0] != END_B) |-> $stable(slot_sel));

    // R3
    slot_value_chk: assert property (@(posedge clk) disable iff (rst)
        (t_q[BIT_W-1:0] == END_B) |-> (slot_sel == t_q[CNT_W-1:BIT_W] + SLOT_W'(1)));

    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (t_q[BIT_W-1:0] == END_B && slot_byte != '0)
        |=> (ser_data == $past(slot_byte[SLOT_BITS-1])));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (t_q[BIT_W-1:0] == END_B && slot_byte == '0) |=> (ser_data == FILL_TOP));

endmodule

bind tdm_frame_serializer tdm_frame_serializer_chk #(
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS),
    .FILL_EN   (FILL_EN),
    .FILL_CODE (FILL_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_sel   (slot_sel),
    .slot_byte  (slot_byte),
    .ser_data   (ser_data),
    .frame_sync (frame_sync)
);

// File: tb/tdm_frame_serializer_tb.sv
module tdm_frame_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] slot_sel;
    logic [7:0] slot_byte;
    logic       ser_data;
    logic       frame_sync;

    logic [7:0] chan [32];

    int errors = 0;
    int checks = 0;
    int n = 0;
    bit after_mid = 1'b0;
    logic [7:0] cur_raw, cur_tx, nxt_raw, nxt_tx;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb slot_byte = chan[slot_sel];

    tdm_frame_serializer u_dut (
        .clk        (clk),
        .rst        (rst),
        .slot_sel   (slot_sel),
        .slot_byte  (slot_byte),
        .ser_data   (ser_data),
        .frame_sync (frame_sync)
    );

    function automatic logic [7:0] line_byte(input logic [7:0] b);
        return (b == 8'h00) ? 8'h02 : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at bit time %0d: actual=%0h expected=%0h", req, n, act, exp);
        end
    endtask

    task automatic shuffle_chan();
        for (int i = 0; i < 32; i++) begin
            int r = int'($urandom % 8);
            chan[i] = (r == 0) ? 8'h00 : 8'($urandom);
        end
        chan[0]  = 8'h00;
        chan[31] = 8'h00;
        chan[1]  = 8'h02;
        chan[2]  = 8'h80;
        chan[3]  = 8'h01;
        chan[4]  = 8'hFF;
    endtask

    // One bit time: compare outputs with the model, then record the loaded byte
    task automatic step_check();
        int  b = n % 8;
        int  exp_slot = ((n + 1) / 8) % 32;
        bit  exp_sync = ((n % 256) == 255);
        logic exp_bit;
        string tag;
        if (b == 0 && n >= 8) begin
            cur_raw = nxt_raw;
            cur_tx  = nxt_tx;
        end
        exp_bit = (n < 8) ? 1'b1 : cur_tx[7 - b];
        chk(frame_sync == exp_sync, after_mid ? "R8" : "R2", frame_sync, exp_sync);
        chk(slot_sel == 5'(exp_slot), "R3", slot_sel, exp_slot);
        if (n < 8)               tag = "R7";
        else if (b == 0)         tag = "R4";
        else if (cur_raw == 8'h00) tag = "R5";
        else                     tag = "R6";
        chk(ser_data == exp_bit, tag, ser_data, exp_bit);
        if (b == 7) begin
            nxt_raw = slot_byte;
            nxt_tx  = line_byte(slot_byte);
        end
        if ((n % 256) == 100) shuffle_chan();
    endtask

    task automatic check_reset_outputs();
        chk(ser_data == 1'b1, "R1", ser_data, 1);
        chk(frame_sync == 1'b0, "R1", frame_sync, 0);
        chk(slot_sel == 5'd0, "R1", slot_sel, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        shuffle_chan();
        cur_raw = 8'hFF; cur_tx = 8'hFF; nxt_raw = 8'hFF; nxt_tx = 8'hFF;
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        n = 0;
        #1;
        step_check();
        for (int c = 0; c < 700; c++) begin
            @(negedge clk);
            n++;
            step_check();
        end
        // Reset in the middle of a timeslot (R8)
        rst = 1'b1;
        @(negedge clk);
        check_reset_outputs();
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        after_mid = 1'b1;
        n = 0;
        #1;
        step_check();
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            n++;
            step_check();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule